// File: doc/BRIEF.md
# Four-Lane Parallel Sine Tone Generator

This block produces a digital sinusoid whose sample rate is four times its clock. On every enabled clock it emits one 64-bit stream word that carries four consecutive 16-bit signed samples of the same waveform. The word is meant for a converter interface that accepts several samples per clock. With a 64 MHz clock this gives 256 MSPS, and the reset tone is 5 MHz.

A single 32-bit phase accumulator is shared by four lanes. Lane k reads the phase `acc + k*inc`, and the accumulator then advances by `4*inc`, so the four lanes together make one contiguous sample stream. Each lane converts the top 10 phase bits into a sample through a quarter-wave table. The table is computed when the design is elaborated and uses the sine's symmetry to cover the whole cycle. Software sets the frequency by loading a new phase increment. The new value takes effect for all four lanes on the same word.

Top module: `tone4_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_data` clear to zero, the phase accumulator clears to zero, and the increment returns to 83886080 (5 MHz at 256 MSPS). The first word after reset therefore starts at phase 0 with that increment.
- R2: `out_valid` in a cycle equals the `tone_en` value sampled at the preceding rising edge. Each enabled edge yields exactly one word.
- R3: A sample for a 32-bit phase p is built from n = p[31:22]. Its value is 32767*sin(2*pi*(n+0.5)/1024), rounded half away from zero, as 16-bit two's complement. A sample is never positive when n[9] is 1 and never negative when n[9] is 0.
- R4: Lane k (k = 0..3) takes phase acc + k*inc and occupies `out_data[16k+15:16k]`. Lane 0 holds the earliest sample.
- R5: On each enabled edge the accumulator grows by 4*inc, modulo 2^32. While `tone_en` is low, both the accumulator and `out_data` hold their values.
- R6: A `freq_load` pulse at an edge captures `freq_word` as the new increment, whether the block is enabled or not. The word produced at that same edge still uses the old increment for all lanes and for the accumulator step. The next word uses the new increment for all four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_en | input | 1 | Produce one output word at this edge |
| freq_load | input | 1 | Capture `freq_word` as the phase increment |
| freq_word | input | 32 | New per-sample phase increment |
| out_valid | output | 1 | `out_data` holds a fresh word |
| out_data | output | 64 | Four packed signed samples, lane 0 in the low bits |

## Verification
The scoreboard follows the accumulator and increment from the requirements alone. It computes each sample directly from the sine, without any quarter-wave folding. A lane offset or lane order error would scramble the four slots of the word. A wrong mirror or negate in a quadrant would corrupt exactly one quarter of the wave. This shows up in the sweep with an increment of one table step per sample, which visits every index. An increment close to 2^32 drives the lane phases across the wrap point. A load issued in the same edge as a word checks that a design switching the increment early, or only for some lanes, fails. Gaps in `tone_en` and a mid-run reset check hold and clearing behaviour.

// File: rtl/tone4_pkg.sv
// Package tone4_pkg
// Shared sizes and the elaboration-time sine sample function for the
// four-lane tone generator. Assumes the table index is at least 3 bits.
package tone4_pkg;

    localparam int LANES_DEF    = 4;
    localparam int SAMPLE_W_DEF = 16;
    localparam int PHASE_W_DEF  = 32;
    localparam int LUT_BITS_DEF = 10;
    localparam logic [31:0] INC_DEF = 32'd83886080;

    // Quarter-wave entry idx of a full table with 2**lut_bits points,
    // sampled at half-step offsets and rounded half away from zero.
    function automatic int quarter_sample(int idx, int lut_bits, int amp);
        real ang;
        real v;
        ang = 2.0 * 3.14159265358979323846 * (real'(idx) + 0.5) / real'(1 << lut_bits);
        v   = real'(amp) * $sin(ang);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        else
            return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/tone4_phase_ctrl.sv
// Module tone4_phase_ctrl
// Holds the phase increment register and the shared phase accumulator.
// The accumulator advances by LANES increments per enabled clock.
// Assumes: synchronous active-low reset; a load and an advance in the
// same edge advance by the old increment.
module tone4_phase_ctrl #(
    parameter int          PHASE_W     = 32,
    parameter int          LANES       = 4,
    parameter logic [31:0] DEFAULT_INC = 32'd83886080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tone_en,
    input  logic               freq_load,
    input  logic [PHASE_W-1:0] freq_word,
    output logic [PHASE_W-1:0] acc_o,
    output logic [PHASE_W-1:0] inc_o
);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] inc_q;
    logic [PHASE_W-1:0] step;

    // Phase advance for one output word
    assign step = inc_q * PHASE_W'(LANES);

    // Increment register: reset to default, load on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            inc_q <= PHASE_W'(DEFAULT_INC);
        else if (freq_load)
            inc_q <= freq_word;
    end

    // Shared accumulator: advance once per produced word
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (tone_en)
            acc_q <= acc_q + step;
    end

    assign acc_o = acc_q;
    assign inc_o = inc_q;

    // R5: accumulator holds while idle
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_en |=> $stable(acc_q));

    // R6: increment changes only on a load
    a_r6_inc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_load |=> $stable(inc_q));

endmodule

// File: rtl/tone4_sine_lane.sv
// Module tone4_sine_lane
// One lane: offsets the shared phase by LANE_IDX increments, keeps the
// top LUT_BITS bits and folds them onto a quarter-wave table built at
// elaboration. Purely combinational. The clock and reset serve only the
// embedded check.
module tone4_sine_lane #(
    parameter int PHASE_W  = 32,
    parameter int SAMPLE_W = 16,
    parameter int LUT_BITS = 10,
    parameter int LANE_IDX = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PHASE_W-1:0]         acc,
    input  logic [PHASE_W-1:0]         inc,
    output logic signed [SAMPLE_W-1:0] sample
);

    localparam int QBITS  = LUT_BITS - 2;
    localparam int QDEPTH = 1 << QBITS;
    localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;

    logic signed [SAMPLE_W-1:0] rom [QDEPTH];
    logic [LUT_BITS-1:0]        lut_idx;
    logic [QBITS-1:0]           fine;
    logic [QBITS-1:0]           addr;
    logic signed [SAMPLE_W-1:0] mag;

    // Quarter-wave table computed at elaboration
    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        localparam logic signed [SAMPLE_W-1:0] VAL =
            SAMPLE_W'(tone4_pkg::quarter_sample(g, LUT_BITS, AMP));
        assign rom[g] = VAL;
    end

    // Lane phase, reduced to the table index
    assign lut_idx = LUT_BITS'((acc + inc * PHASE_W'(LANE_IDX)) >> (PHASE_W - LUT_BITS));
    assign fine    = lut_idx[QBITS-1:0];

    // Fold quadrant onto the quarter table and restore sign
    always_comb begin
        addr   = lut_idx[QBITS] ? ~fine : fine;
        mag    = rom[addr];
        sample = lut_idx[LUT_BITS-1] ? -mag : mag;
    end

    // R3: sign follows the half-wave of the phase
    a_r3_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
        lut_idx[LUT_BITS-1] ? (sample <= 0) : (sample >= 0));

endmodule

// File: rtl/tone4_gen.sv
// Module tone4_gen (top)
// Four-lane parallel tone generator: four phase-staggered lanes share
// one accumulator and produce four consecutive samples per clock, which
// are registered as a single packed stream word with a valid flag.
// Assumes: synchronous active-low reset; no backpressure at the output.
module tone4_gen #(
    parameter int          LANES       = tone4_pkg::LANES_DEF,
    parameter int          SAMPLE_W    = tone4_pkg::SAMPLE_W_DEF,
    parameter int          PHASE_W     = tone4_pkg::PHASE_W_DEF,
    parameter int          LUT_BITS    = tone4_pkg::LUT_BITS_DEF,
    parameter logic [31:0] DEFAULT_INC = tone4_pkg::INC_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tone_en,
    input  logic                      freq_load,
    input  logic [PHASE_W-1:0]        freq_word,
    output logic                      out_valid,
    output logic [LANES*SAMPLE_W-1:0] out_data
);

    localparam int DATA_W = LANES * SAMPLE_W;

    logic [PHASE_W-1:0]  acc;
    logic [PHASE_W-1:0]  inc;
    logic [DATA_W-1:0]   packed_word;

    tone4_phase_ctrl #(
        .PHASE_W     (PHASE_W),
        .LANES       (LANES),
        .DEFAULT_INC (DEFAULT_INC)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_en   (tone_en),
        .freq_load (freq_load),
        .freq_word (freq_word),
        .acc_o     (acc),
        .inc_o     (inc)
    );

    // One lane per sample slot; lane 0 is the earliest sample
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [SAMPLE_W-1:0] smp;
        tone4_sine_lane #(
            .PHASE_W  (PHASE_W),
            .SAMPLE_W (SAMPLE_W),
            .LUT_BITS (LUT_BITS),
            .LANE_IDX (k)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .acc    (acc),
            .inc    (inc),
            .sample (smp)
        );
        assign packed_word[k*SAMPLE_W +: SAMPLE_W] = smp;
    end

    // Output register: capture a word per enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= tone_en;
            if (tone_en)
                out_data <= packed_word;
        end
    end

    // R2: a fresh word only follows an enabled edge
    a_r2_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(tone_en));

    // R5: data holds while idle
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_en |=> $stable(out_data));

endmodule

// File: tb/tb_tone4_gen.sv
// Scoreboard bench for tone4_gen: the driver pushes the expected output
// of every edge; the monitor pops and compares after each edge.
module tb_tone4_gen;

    localparam logic [31:0] DEF_INC = 32'd83886080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tone_en = 1'b0;
    logic        freq_load = 1'b0;
    logic [31:0] freq_word = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [64:0] exp_q [$];
    string       tag_q [$];

    // model state
    logic [31:0] m_acc = '0;
    logic [31:0] m_inc = DEF_INC;
    logic [63:0] m_data = '0;

    always #2.5 clk = ~clk;

    tone4_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_en   (tone_en),
        .freq_load (freq_load),
        .freq_word (freq_word),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R3 model: direct sine of the top 10 phase bits
    function automatic logic [15:0] ref_sample(logic [31:0] p);
        int  n;
        real v;
        n = int'(p[31:22]);
        v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(n) + 0.5) / 1024.0);
        if (v >= 0.0) return 16'($rtoi(v + 0.5));
        else          return 16'(-$rtoi(0.5 - v));
    endfunction

    // Model the coming edge and queue its expected output
    function automatic void model_edge(string tag);
        logic valid;
        if (!rst_n) begin
            m_acc = '0; m_inc = DEF_INC; m_data = '0; valid = 1'b0;
        end else begin
            valid = tone_en;
            if (tone_en) begin
                for (int k = 0; k < 4; k++)
                    m_data[16*k +: 16] = ref_sample(m_acc + m_inc * 32'(k));
                m_acc = m_acc + m_inc * 32'd4;
            end
            if (freq_load) m_inc = freq_word;
        end
        exp_q.push_back({valid, m_data});
        tag_q.push_back(tag);
    endfunction

    // Driver: apply inputs for n edges
    task automatic drive(int n, logic rn, logic en, logic ld, logic [31:0] w, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = rn; tone_en = en; freq_load = ld; freq_word = w;
            model_edge(tag);
        end
    endtask

    // Monitor: compare after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [64:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (out_valid !== e[64]) begin
                    errors++;
                    $display("FAIL %s valid: actual %0b expected %0b", t, out_valid, e[64]);
                end
                checks++;
                if (out_data !== e[63:0]) begin
                    errors++;
                    $display("FAIL %s data: actual %h expected %h", t, out_data, e[63:0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_edge("R1 reset");
        drive(3, 1'b0, 1'b0, 1'b0, 32'd0, "R1 reset");
        // R1/R4: default tone from phase zero
        drive(20, 1'b1, 1'b1, 1'b0, 32'd0, "R1 R4 default tone");
        // R2/R5: idle gap holds data and accumulator
        drive(3, 1'b1, 1'b0, 1'b0, 32'd0, "R2 R5 idle hold");
        drive(6, 1'b1, 1'b1, 1'b0, 32'd0, "R5 resume continuity");
        // R6: load during a produced word
        drive(1, 1'b1, 1'b1, 1'b1, 32'h0123_4567, "R6 load same edge");
        drive(8, 1'b1, 1'b1, 1'b0, 32'd0, "R6 new increment");
        // R6: load while idle
        drive(1, 1'b1, 1'b0, 1'b1, 32'h0040_0000, "R6 load idle");
        // R3: one table step per sample sweeps every index
        drive(260, 1'b1, 1'b1, 1'b0, 32'd0, "R3 full sweep");
        // R4/R5: lanes straddle the wrap point
        drive(1, 1'b1, 1'b1, 1'b1, 32'hFFF0_0000, "R5 load near wrap");
        drive(12, 1'b1, 1'b1, 1'b0, 32'd0, "R4 R5 wrap");
        drive(1, 1'b1, 1'b1, 1'b1, 32'h4000_0000, "R6 quarter step");
        drive(6, 1'b1, 1'b1, 1'b0, 32'd0, "R3 quadrant points");
        // R1: reset mid-run, then load ignored during reset
        drive(2, 1'b0, 1'b1, 1'b1, 32'h1111_1111, "R1 mid reset");
        drive(10, 1'b1, 1'b1, 1'b0, 32'd0, "R1 after reset");
        drive(1, 1'b1, 1'b0, 1'b0, 32'd0, "R2 stop");
        drive(3, 1'b1, 1'b0, 1'b0, 32'd0, "R2 idle");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule